// File: doc/BRIEF.md
# Dual Tachometer Period Capture Timer

This block measures the rotation period of two fans by timing the pulses on their tachometer lines. Each of the two channels has a down counter. A shared prescaler steps both counters, and each counter has its own run bit. When the chosen edge of a channel's tachometer input arrives, the counter value is latched into that channel's capture register and the counter restarts from all ones. The latched value therefore gives the number of prescaled ticks in one pulse period.

Each counter is also compared against a timeout value. When the counter steps onto that value, a timeout flag is raised, which tells software that the fan has stalled. Capture and timeout events set sticky pending flags. Software clears these flags by writing ones to them. Each flag can be routed to a single interrupt line through its own enable bit. All configuration sits behind a small register bus that takes an index, a write strobe and write data, and returns read data combinationally.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset, both counters read all ones. Captures, compares, prescaler, run bits, mode, flags, enables, match config and select values read zero, and `irq_o` is low.
- R2: Run register (index 7): bit 0 runs counter A and bit 1 runs counter B. While its run bit is clear, a counter holds its value. While the bit is set, the counter decrements by one on every prescaler tick.
- R3: Prescaler register (index 6): a tick occurs once every value+1 clock cycles. A value of 0 ticks every cycle and a value of 255 ticks every 256 cycles. Writing this register restarts the division.
- R4: A bus write to a counter register (index 0 for A, 1 for B) loads the written value. The load takes precedence over a decrement in the same cycle.
- R5: Mode register (index 8): bit 4 enables capture, bit 0 and bit 1 enable inputs A and B, and bits 2 and 3 select the edge for A and B (1 = rising, 0 = falling). Each input passes through a two-flop synchronizer. A selected edge captures the counter value into the capture register (index 2 for A, 3 for B), reloads the counter with all ones and sets pending bit 0 (A) or bit 1 (B). The capture register is written on the third clock edge after the input changes. With prescaler 0, a steady period of P cycles captures 2^16 - P.
- R6: An edge of the unselected polarity causes no capture and no flag. So does an edge on a disabled input, or any edge while mode bit 4 is clear.
- R7: Match config register (index 12): bit 0 and bit 1 enable the timeout compare for A and B, which use compare registers 4 and 5. When an enabled counter steps onto its compare value, pending bit 4 (A) or bit 5 (B) is set in that same clock edge.
- R8: Pending register (index 9) is read-only. Writing ones to the clear register (index 10) clears the matching flags, and zero bits leave their flags unchanged. A flag set in the same cycle as its clear stays set.
- R9: `irq_o` is high exactly when some pending bit has its enable set. The enable register is index 11 and uses the same bit layout as the pending register.
- R10: Input select registers (index 13 for A, 14 for B) store and read back their low 4 bits, and writing them has no effect on capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 4 | Register index |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the indexed register |
| tach_a_i | input | 1 | Tachometer input, channel A |
| tach_b_i | input | 1 | Tachometer input, channel B |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can fall in the same cycle: a capture setting pending bit 0, and a software write to the clear register for that same bit. The bench raises the tachometer input, counts the two synchronizer stages and the edge detector, and times the clear write so that it lands on the exact edge where the capture fires. It then reads back the pending register and expects bit 0 to be set. Periods are swept across many values, and each captured count is compared against 2^16 minus the period in cycles.

// File: rtl/tach_timer_pkg.sv
package tach_timer_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_CNT_A = 4'd0;
  localparam logic [REG_AW-1:0] RA_CNT_B = 4'd1;
  localparam logic [REG_AW-1:0] RA_CAP_A = 4'd2;
  localparam logic [REG_AW-1:0] RA_CAP_B = 4'd3;
  localparam logic [REG_AW-1:0] RA_CMP_A = 4'd4;
  localparam logic [REG_AW-1:0] RA_CMP_B = 4'd5;
  localparam logic [REG_AW-1:0] RA_PRE   = 4'd6;
  localparam logic [REG_AW-1:0] RA_RUN   = 4'd7;
  localparam logic [REG_AW-1:0] RA_MODE  = 4'd8;
  localparam logic [REG_AW-1:0] RA_PEND  = 4'd9;
  localparam logic [REG_AW-1:0] RA_CLR   = 4'd10;
  localparam logic [REG_AW-1:0] RA_IEN   = 4'd11;
  localparam logic [REG_AW-1:0] RA_MCFG  = 4'd12;
  localparam logic [REG_AW-1:0] RA_SEL_A = 4'd13;
  localparam logic [REG_AW-1:0] RA_SEL_B = 4'd14;

  localparam int FLG_W     = 6;
  localparam int FLG_CAP_A = 0;
  localparam int FLG_CAP_B = 1;
  localparam int FLG_TO_A  = 4;
  localparam int FLG_TO_B  = 5;

  localparam int MODE_W   = 5;
  localparam int MD_EDGE0 = 2;  // edge select of channel n sits at MD_EDGE0 + n
  localparam int MD_CAP   = 4;
endpackage

// File: rtl/tach_presc.sv
module tach_presc #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;

  assign tick_o = (pre_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (tick_o)    pre_q <= '0;
    else                pre_q <= pre_q + PRE_W'(1);
  end

  a_r3_no_early_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && !restart_i) |=> !tick_o);
endmodule

// File: rtl/tach_chan.sv
module tach_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tach_i,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             cap_mode_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             cmp_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             hit_o,
  output logic             match_o
);
  logic [2:0]       sync_q;  // [0],[1] synchronizer, [2] edge history
  logic [CNT_W-1:0] cnt_q, cap_q, dec;
  logic             rise_ev, fall_ev, step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tach_i};
  end

  assign rise_ev = sync_q[1] & ~sync_q[2];
  assign fall_ev = ~sync_q[1] & sync_q[2];
  assign hit_o   = en_i & cap_mode_i & (rise_i ? rise_ev : fall_ev);
  assign step    = run_i & tick_i;
  assign dec     = cnt_q - CNT_W'(1);
  assign match_o = step & ~ld_i & ~hit_o & cmp_en_i & (dec == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '1;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (hit_o) cnt_q <= '1;
    else if (step)  cnt_q <= dec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (hit_o) cap_q <= cnt_q;
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;

  a_r2_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_i && !hit_o) |=> $stable(cnt_q));
  a_r2_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !ld_i && !hit_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r4_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_val_i)));
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !ld_i) |=> (cnt_q == '1));
  a_r5_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> (cap_q == $past(cnt_q)));
endmodule

// File: rtl/tach_capture_timer.sv
module tach_capture_timer
  import tach_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int SEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              tach_a_i,
  input  logic              tach_b_i,
  output logic              irq_o
);
  localparam int NCH = 2;

  logic [PRE_W-1:0]  div_q;
  logic [NCH-1:0]    run_q, mcfg_q;
  logic [MODE_W-1:0] mode_q;
  logic [FLG_W-1:0]  pend_q, ien_q, set, clr;
  logic [CNT_W-1:0]  cmp_q [NCH];
  logic [SEL_W-1:0]  sel_q [NCH];
  logic [CNT_W-1:0]  cnt [NCH];
  logic [CNT_W-1:0]  cap [NCH];
  logic [NCH-1:0]    hit, match, tach, ld;
  logic              tick, wr_pre;

  assign tach   = {tach_b_i, tach_a_i};
  assign wr_pre = bus_we_i && (bus_addr_i == RA_PRE);

  tach_presc #(.PRE_W(PRE_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (div_q),
    .restart_i(wr_pre),
    .tick_o   (tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign ld[ch] = bus_we_i && (bus_addr_i == ((ch == 0) ? RA_CNT_A : RA_CNT_B));

    tach_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tach_i    (tach[ch]),
      .tick_i    (tick),
      .run_i     (run_q[ch]),
      .en_i      (mode_q[ch]),
      .rise_i    (mode_q[MD_EDGE0+ch]),
      .cap_mode_i(mode_q[MD_CAP]),
      .ld_i      (ld[ch]),
      .ld_val_i  (bus_wdata_i),
      .cmp_i     (cmp_q[ch]),
      .cmp_en_i  (mcfg_q[ch]),
      .cnt_o     (cnt[ch]),
      .cap_o     (cap[ch]),
      .hit_o     (hit[ch]),
      .match_o   (match[ch])
    );
  end

  always_comb begin
    set            = '0;
    set[FLG_CAP_A] = hit[0];
    set[FLG_CAP_B] = hit[1];
    set[FLG_TO_A]  = match[0];
    set[FLG_TO_B]  = match[1];
    clr = (bus_we_i && bus_addr_i == RA_CLR) ? bus_wdata_i[FLG_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      run_q  <= '0;
      mode_q <= '0;
      pend_q <= '0;
      ien_q  <= '0;
      mcfg_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        cmp_q[i] <= '0;
        sel_q[i] <= '0;
      end
    end else begin
      pend_q <= (pend_q & ~clr) | set;  // set wins over clear
      if (bus_we_i) begin
        case (bus_addr_i)
          RA_PRE:   div_q    <= bus_wdata_i[PRE_W-1:0];
          RA_RUN:   run_q    <= bus_wdata_i[NCH-1:0];
          RA_MODE:  mode_q   <= bus_wdata_i[MODE_W-1:0];
          RA_IEN:   ien_q    <= bus_wdata_i[FLG_W-1:0];
          RA_MCFG:  mcfg_q   <= bus_wdata_i[NCH-1:0];
          RA_CMP_A: cmp_q[0] <= bus_wdata_i;
          RA_CMP_B: cmp_q[1] <= bus_wdata_i;
          RA_SEL_A: sel_q[0] <= bus_wdata_i[SEL_W-1:0];
          RA_SEL_B: sel_q[1] <= bus_wdata_i[SEL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr_i)
      RA_CNT_A: bus_rdata_o = cnt[0];
      RA_CNT_B: bus_rdata_o = cnt[1];
      RA_CAP_A: bus_rdata_o = cap[0];
      RA_CAP_B: bus_rdata_o = cap[1];
      RA_CMP_A: bus_rdata_o = cmp_q[0];
      RA_CMP_B: bus_rdata_o = cmp_q[1];
      RA_PRE:   bus_rdata_o = CNT_W'(div_q);
      RA_RUN:   bus_rdata_o = CNT_W'(run_q);
      RA_MODE:  bus_rdata_o = CNT_W'(mode_q);
      RA_PEND:  bus_rdata_o = CNT_W'(pend_q);
      RA_IEN:   bus_rdata_o = CNT_W'(ien_q);
      RA_MCFG:  bus_rdata_o = CNT_W'(mcfg_q);
      RA_SEL_A: bus_rdata_o = CNT_W'(sel_q[0]);
      RA_SEL_B: bus_rdata_o = CNT_W'(sel_q[1]);
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |(pend_q & ien_q);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set) |=> ((pend_q & $past(set)) == $past(set)));
  a_r8_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr & ~set)) |=> ((pend_q & $past(clr & ~set)) == '0));
  a_r9_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((|set) || (bus_we_i && bus_addr_i == RA_IEN)));
endmodule

// File: tb/tb_tach_capture_timer.sv
`timescale 1ns/100ps
module tb_tach_capture_timer;
  localparam logic [3:0] I_CNT_A = 0, I_CNT_B = 1, I_CAP_A = 2, I_CAP_B = 3,
    I_CMP_A = 4, I_CMP_B = 5, I_PRE = 6, I_RUN = 7, I_MODE = 8, I_PEND = 9,
    I_CLR = 10, I_IEN = 11, I_MCFG = 12, I_SEL_A = 13, I_SEL_B = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ta = 1'b0, tb = 1'b0;
  logic        irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tach_capture_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tach_a_i(ta), .tach_b_i(tb),
    .irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rdchk(string req, logic [3:0] a, logic [15:0] exp);
    addr = a;
    #0.1;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rdchk("R1 cnt_a", I_CNT_A, 16'hFFFF);
    rdchk("R1 cnt_b", I_CNT_B, 16'hFFFF);
    rdchk("R1 cap_a", I_CAP_A, 16'h0000);
    rdchk("R1 pend", I_PEND, 16'h0000);
    rdchk("R1 mode", I_MODE, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 stopped counter holds
    repeat (5) @(posedge clk); #1;
    rdchk("R2 hold", I_CNT_A, 16'hFFFF);

    // R4 load, R2 run at prescaler 0
    wr(I_CNT_A, 16'h1234);
    rdchk("R4 load", I_CNT_A, 16'h1234);
    wr(I_RUN, 16'h0001);
    repeat (7) @(posedge clk); #1;
    rdchk("R2 run a", I_CNT_A, 16'h1234 - 16'd7);
    rdchk("R2 b stopped", I_CNT_B, 16'hFFFF);
    wr(I_CNT_A, 16'h0100);
    rdchk("R4 load over step", I_CNT_A, 16'h0100);
    repeat (3) @(posedge clk); #1;
    rdchk("R4 after load", I_CNT_A, 16'h00FD);

    // R3 prescaler division, phase-free windows
    wr(I_RUN, 16'h0000); wr(I_CNT_A, 16'h1000); wr(I_PRE, 16'd3); wr(I_RUN, 16'h0001);
    repeat (40) @(posedge clk); #1;
    rdchk("R3 div4", I_CNT_A, 16'h1000 - 16'd10);
    wr(I_RUN, 16'h0000); wr(I_CNT_A, 16'h1000); wr(I_PRE, 16'd255); wr(I_RUN, 16'h0001);
    repeat (512) @(posedge clk); #1;
    rdchk("R3 div256", I_CNT_A, 16'h0FFE);
    wr(I_PRE, 16'd0);

    // R5 capture on rising edge of A
    wr(I_MODE, 16'h0015);
    wr(I_CNT_A, 16'h8000);
    repeat (4) @(posedge clk);
    @(negedge clk) ta = 1'b1;
    repeat (3) @(posedge clk); #1;
    rdchk("R5 cap value", I_CAP_A, 16'h7FFA);
    rdchk("R5 reload", I_CNT_A, 16'hFFFF);
    rdchk("R5 flag a", I_PEND, 16'h0001);
    // R5 period sweep
    for (int p = 5; p <= 40; p += (p < 12) ? 1 : 14) begin
      @(negedge clk) ta = 1'b0;
      repeat (p - 3) @(posedge clk);
      @(negedge clk) ta = 1'b1;
      repeat (3) @(posedge clk); #1;
      rdchk($sformatf("R5 period %0d", p), I_CAP_A, 16'(32'h10000 - p));
    end
    wr(I_CLR, 16'h003F);
    rdchk("R8 cleared", I_PEND, 16'h0000);

    // R6 wrong polarity on B (falling selected), A disabled
    wr(I_RUN, 16'h0003);
    wr(I_MODE, 16'h0012);
    @(negedge clk) begin tb = 1'b1; ta = 1'b0; end
    repeat (6) @(posedge clk); #1;
    rdchk("R6 wrong edge/disabled", I_PEND, 16'h0000);
    rdchk("R6 cap_b untouched", I_CAP_B, 16'h0000);
    // R5 falling capture on B
    wr(I_CNT_B, 16'h4000);
    repeat (2) @(posedge clk);
    @(negedge clk) tb = 1'b0;
    repeat (3) @(posedge clk); #1;
    rdchk("R5 cap b falling", I_CAP_B, 16'h3FFC);
    rdchk("R5 flag b", I_PEND, 16'h0002);
    wr(I_CLR, 16'h0002);
    // R6 mode bit clear blocks capture
    wr(I_MODE, 16'h000F);
    @(negedge clk) begin ta = 1'b1; tb = 1'b1; end
    repeat (6) @(posedge clk); #1;
    rdchk("R6 mode off", I_PEND, 16'h0000);

    // R7 timeout compare
    wr(I_MODE, 16'h0000);
    wr(I_MCFG, 16'h0001);
    wr(I_CMP_A, 16'h04FB);
    wr(I_CMP_B, 16'h01F0);
    wr(I_CNT_B, 16'h0200);
    wr(I_CNT_A, 16'h0500);
    repeat (4) @(posedge clk); #1;
    rdchk("R7 not yet", I_PEND, 16'h0000);
    @(posedge clk); #1;
    rdchk("R7 timeout a", I_PEND, 16'h0010);
    repeat (30) @(posedge clk); #1;
    rdchk("R7 b disabled", I_PEND, 16'h0010);
    wr(I_MCFG, 16'h0003);
    wr(I_CNT_B, 16'h0200);
    repeat (15) @(posedge clk); #1;
    rdchk("R7 b not yet", I_PEND, 16'h0010);
    @(posedge clk); #1;
    rdchk("R7 timeout b", I_PEND, 16'h0030);

    // R8 partial clear, R9 interrupt
    wr(I_CLR, 16'h0010);
    rdchk("R8 partial clear", I_PEND, 16'h0020);
    wr(I_IEN, 16'h0010);
    chk("R9 irq masked", {15'd0, irq}, 16'h0000);
    wr(I_IEN, 16'h0020);
    chk("R9 irq on", {15'd0, irq}, 16'h0001);
    wr(I_CLR, 16'h0020);
    chk("R9 irq off", {15'd0, irq}, 16'h0000);
    rdchk("R8 all clear", I_PEND, 16'h0000);

    // R8 capture and clear on the same edge: set wins
    wr(I_MODE, 16'h0015);
    @(negedge clk) ta = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) ta = 1'b1;
    repeat (2) @(posedge clk);
    wr(I_CLR, 16'h0001);
    rdchk("R8 set wins", I_PEND, 16'h0001);
    wr(I_IEN, 16'h0001);
    chk("R9 irq capture", {15'd0, irq}, 16'h0001);
    wr(I_CLR, 16'h0001);
    rdchk("R8 clear after", I_PEND, 16'h0000);

    // R10 select registers
    wr(I_SEL_A, 16'h0005);
    wr(I_SEL_B, 16'hFFFA);
    rdchk("R10 sel a", I_SEL_A, 16'h0005);
    rdchk("R10 sel b", I_SEL_B, 16'h000A);
    rdchk("R10 no capture", I_PEND, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule